// File: doc/BRIEF.md
# Capture, Compare and PWM Timer Companion

This block sits beside a free-running timer. It uses one 16-bit data register for one of three jobs, picked by a 4-bit mode code. In capture modes the register latches the timer when the pin input has the selected edge. The pin input is synchronised and edge-detected first, and can be prescaled to every 4th or 16th rising edge. In compare modes the register holds a value that is matched against the timer. A match can toggle, set or clear an output pin, raise an interrupt flag, or issue a one-cycle special-event pulse. In PWM mode the block makes a pulse-width output with 10-bit resolution. The duty value is double-buffered. It is compared against a count built from the low 8 bits of the timer and a 2-bit fine count.

Software reaches the block through a small byte-wide register bus. The writes are synchronous and the reads are combinational. Address 0 is the low data byte and address 1 the high data byte. Address 2 is the control byte: bits 3:0 hold the mode code, bits 5:4 hold the fine duty bits, and bits 7:6 always read as zero. Address 3 holds the interrupt flag in bit 0 and zeros above it.

Top module: `cap_cmp_pwm`

## Requirements
- R1: After reset the following are all zero: the data register, the control byte, the flag, pinOut, pinOe and evtPulse.
- R2: A write to address 0 or 1 sets the low or high data byte. A write to address 2 stores bits 5:0 of the written byte. Bits 7:6 of address 2 always read as zero.
- R3: Mode codes 0000, 0001 and 0011 are disabled modes. In these modes pinOe is 0 and the pin latch is cleared on the next clock. No capture, flag or evtPulse occurs.
- R4: Mode 0101 captures on a rising edge of capIn and mode 0100 captures on a falling edge. The timer value sampled on the third clock edge after the input change is loaded into the data register, and the flag is set. The edge of the other polarity does nothing.
- R5: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The prescale count clears on every write to address 2.
- R6: Mode 0010 drives the pin (pinOe=1). On the first clock where timerVal equals the data register, the pin toggles and the flag is set. A match that stays does not toggle the pin again.
- R7: Writing mode 1000 clears the pin, and a match then sets it. Writing mode 1001 sets the pin, and a match then clears it. Both modes drive pinOe=1 and set the flag on a match.
- R8: Mode 1010 sets only the flag on a match. pinOe is 0 and the pin latch keeps its value.
- R9: Mode 1011 sets the flag on a match and raises evtPulse for exactly one cycle, in the cycle after the matching edge. pinOe is 0.
- R10: Modes 11xx select PWM, with pinOe=1. The duty value is {data[7:0], ctrl[5:4]} and is loaded into the active duty when periodStart is high. The output for count c={timerVal[7:0], pwmFine} is (c < active duty), seen one clock later.
- R11: In PWM mode, a duty value above the largest count in the period gives a constant high output, and a duty value of 0 gives a constant low output.
- R12: The flag stays set until a write to address 3 clears it. If a set and the clear fall on the same clock, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data byte |
| busRdData | output | 8 | Combinational read data |
| timerVal | input | 16 | Free-running timer value |
| pwmFine | input | 2 | Fine count below the 8-bit PWM timer |
| periodStart | input | 1 | High in the first cycle of each PWM period |
| capIn | input | 1 | Asynchronous pin input |
| pinOut | output | 1 | Pin output value |
| pinOe | output | 1 | Pin output enable |
| intFlag | output | 1 | Sticky interrupt flag |
| evtPulse | output | 1 | One-cycle special-event trigger |

## Verification
The hardest case to reach is the prescale count being cleared by a control write part-way through a group of rising edges. It is invisible at the ports until the capture lands one edge group later than it would have. The bench gives two rising edges in mode 0110 and rewrites the same mode. It then shows that edges 1 to 3 after the write leave the register unchanged and edge 4 loads it. In the same way, a duty change in PWM is issued with periodStart held low for a whole period. This shows that the old duty stays in force until the next period start.

// File: rtl/cap_cmp_pwm_pkg.sv
package cap_cmp_pwm_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam int ADDR_W = 2;
  localparam int FINE_W = 2;
  localparam int MODE_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_DLO  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DHI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd3;

  localparam logic [MODE_W-1:0] M_CMP_TGL  = 4'b0010;
  localparam logic [MODE_W-1:0] M_CAP_FALL = 4'b0100;
  localparam logic [MODE_W-1:0] M_CAP_RISE = 4'b0101;
  localparam logic [MODE_W-1:0] M_CAP_LO   = 4'b0110;
  localparam logic [MODE_W-1:0] M_CAP_HI   = 4'b0111;
  localparam logic [MODE_W-1:0] M_CMP_SET  = 4'b1000;
  localparam logic [MODE_W-1:0] M_CMP_CLR  = 4'b1001;
  localparam logic [MODE_W-1:0] M_CMP_FLAG = 4'b1010;
  localparam logic [MODE_W-1:0] M_CMP_EVT  = 4'b1011;

  typedef struct packed {
    logic capLoad;
    logic flagSet;
    logic pinSet;
    logic pinClr;
    logic pinToggle;
    logic pwmMode;
    logic pinDrive;
  } strobe_t;

  function automatic logic isCapture(logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction

  function automatic logic isPwm(logic [MODE_W-1:0] m);
    return m[3:2] == 2'b11;
  endfunction

  function automatic logic isCompare(logic [MODE_W-1:0] m);
    return (m == M_CMP_TGL) || (m[3:2] == 2'b10);
  endfunction

  function automatic logic isOff(logic [MODE_W-1:0] m);
    return !(isCapture(m) || isPwm(m) || isCompare(m));
  endfunction
endpackage

// File: rtl/cap_cmp_pwm_ctrl.sv
module cap_cmp_pwm_ctrl
  import cap_cmp_pwm_pkg::*;
#(
  parameter int SYNC_N = 2,
  parameter int PRE_LO = 4,
  parameter int PRE_HI = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeQ,
  input  logic              ctrlWr,
  input  logic [MODE_W-1:0] ctrlWrMode,
  input  logic [DATA_W-1:0] dataQ,
  input  logic [DATA_W-1:0] timerVal,
  input  logic              capIn,
  output strobe_t           strobe,
  output logic              evtPulse
);
  localparam int PRE_W = $clog2(PRE_HI);
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(PRE_LO - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(PRE_HI - 1);

  // input synchroniser plus one history stage for edge detection
  logic [SYNC_N:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_N-1:0], capIn};
  end

  logic riseEdge, fallEdge;
  assign riseEdge = syncQ[SYNC_N-1] & ~syncQ[SYNC_N];
  assign fallEdge = ~syncQ[SYNC_N-1] & syncQ[SYNC_N];

  // edge prescaler
  logic             preMode;
  logic [PRE_W-1:0] preLast;
  logic [PRE_W-1:0] preCnt;
  assign preMode = (modeQ == M_CAP_LO) || (modeQ == M_CAP_HI);
  assign preLast = (modeQ == M_CAP_HI) ? LAST_HI : LAST_LO;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (ctrlWr || !preMode) preCnt <= '0;
    else if (riseEdge)          preCnt <= (preCnt == preLast) ? '0 : preCnt + 1'b1;
  end

  logic capEvent;
  always_comb begin
    unique case (modeQ)
      M_CAP_FALL:         capEvent = fallEdge;
      M_CAP_RISE:         capEvent = riseEdge;
      M_CAP_LO, M_CAP_HI: capEvent = riseEdge && (preCnt == preLast);
      default:            capEvent = 1'b0;
    endcase
  end

  // compare: act on the first cycle of equality only
  logic matchNow, matchPrev, matchRise;
  assign matchNow = (timerVal == dataQ);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else       matchPrev <= matchNow;
  end
  assign matchRise = matchNow && !matchPrev && isCompare(modeQ) && !ctrlWr;

  logic entrySet, entryClr, offClr;
  assign entrySet = ctrlWr && (ctrlWrMode == M_CMP_CLR);
  assign entryClr = ctrlWr && (ctrlWrMode == M_CMP_SET);
  assign offClr   = !ctrlWr && isOff(modeQ);

  always_comb begin
    strobe.capLoad   = capEvent;
    strobe.flagSet   = capEvent || matchRise;
    strobe.pinSet    = entrySet || (matchRise && modeQ == M_CMP_SET);
    strobe.pinClr    = entryClr || offClr || (matchRise && modeQ == M_CMP_CLR);
    strobe.pinToggle = matchRise && (modeQ == M_CMP_TGL);
    strobe.pwmMode   = isPwm(modeQ);
    strobe.pinDrive  = isPwm(modeQ) || (modeQ == M_CMP_TGL) ||
                       (modeQ == M_CMP_SET) || (modeQ == M_CMP_CLR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPulse <= 1'b0;
    else       evtPulse <= matchRise && (modeQ == M_CMP_EVT);
  end
endmodule

// File: rtl/cap_cmp_pwm_dp.sv
module cap_cmp_pwm_dp
  import cap_cmp_pwm_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [DATA_W-1:0] timerVal,
  input  logic [FINE_W-1:0] pwmFine,
  input  logic              periodStart,
  input  strobe_t           strobe,
  output logic [DATA_W-1:0] dataQ,
  output logic [MODE_W-1:0] modeQ,
  output logic              pinOut,
  output logic              pinOe,
  output logic              intFlag
);
  localparam int DUTY_W = TMR_W + FINE_W;
  localparam int PAD_W  = BYTE_W - FINE_W - MODE_W;

  logic wrLo, wrHi, wrCtrl, wrFlag;
  assign wrLo   = busWrEn && (busAddr == ADDR_DLO);
  assign wrHi   = busWrEn && (busAddr == ADDR_DHI);
  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);
  assign wrFlag = busWrEn && (busAddr == ADDR_FLAG);

  // shared data register: bus write beats capture per byte lane
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
    end else begin
      if (wrLo)                 dataQ[BYTE_W-1:0] <= busWrData;
      else if (strobe.capLoad)  dataQ[BYTE_W-1:0] <= timerVal[BYTE_W-1:0];
      if (wrHi)                 dataQ[DATA_W-1:BYTE_W] <= busWrData;
      else if (strobe.capLoad)  dataQ[DATA_W-1:BYTE_W] <= timerVal[DATA_W-1:BYTE_W];
    end
  end

  logic [FINE_W-1:0] fineQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      fineQ <= '0;
    end else if (wrCtrl) begin
      modeQ <= busWrData[MODE_W-1:0];
      fineQ <= busWrData[MODE_W+FINE_W-1:MODE_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               intFlag <= 1'b0;
    else if (strobe.flagSet) intFlag <= 1'b1;
    else if (wrFlag)         intFlag <= 1'b0;
  end

  // PWM: buffered duty becomes active at period start
  logic [DUTY_W-1:0] dutyBuf, dutyAct, dutyUse, pwmCount;
  assign dutyBuf  = {dataQ[TMR_W-1:0], fineQ};
  assign pwmCount = {timerVal[TMR_W-1:0], pwmFine};
  assign dutyUse  = periodStart ? dutyBuf : dutyAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dutyAct <= '0;
    else if (periodStart) dutyAct <= dutyBuf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pinOut <= 1'b0;
    else if (strobe.pwmMode)   pinOut <= (pwmCount < dutyUse);
    else if (strobe.pinSet)    pinOut <= 1'b1;
    else if (strobe.pinClr)    pinOut <= 1'b0;
    else if (strobe.pinToggle) pinOut <= ~pinOut;
  end

  assign pinOe = strobe.pinDrive;

  always_comb begin
    unique case (busAddr)
      ADDR_DLO:  busRdData = dataQ[BYTE_W-1:0];
      ADDR_DHI:  busRdData = dataQ[DATA_W-1:BYTE_W];
      ADDR_CTRL: busRdData = {{PAD_W{1'b0}}, fineQ, modeQ};
      default:   busRdData = {{(BYTE_W-1){1'b0}}, intFlag};
    endcase
  end
endmodule

// File: rtl/cap_cmp_pwm.sv
module cap_cmp_pwm
  import cap_cmp_pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int SYNC_N = 2,
  parameter int PRE_LO = 4,
  parameter int PRE_HI = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [DATA_W-1:0] timerVal,
  input  logic [FINE_W-1:0] pwmFine,
  input  logic              periodStart,
  input  logic              capIn,
  output logic              pinOut,
  output logic              pinOe,
  output logic              intFlag,
  output logic              evtPulse
);
  strobe_t           strobe;
  logic [DATA_W-1:0] dataQ;
  logic [MODE_W-1:0] modeQ;
  logic              ctrlWr;

  assign ctrlWr = busWrEn && (busAddr == ADDR_CTRL);

  cap_cmp_pwm_ctrl #(
    .SYNC_N(SYNC_N), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeQ(modeQ), .ctrlWr(ctrlWr),
    .ctrlWrMode(busWrData[MODE_W-1:0]), .dataQ(dataQ), .timerVal(timerVal),
    .capIn(capIn), .strobe(strobe), .evtPulse(evtPulse)
  );

  cap_cmp_pwm_dp #(.TMR_W(TMR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .timerVal(timerVal),
    .pwmFine(pwmFine), .periodStart(periodStart), .strobe(strobe),
    .dataQ(dataQ), .modeQ(modeQ), .pinOut(pinOut), .pinOe(pinOe),
    .intFlag(intFlag)
  );
endmodule

// File: rtl/cap_cmp_pwm_chk.sv
module cap_cmp_pwm_chk
  import cap_cmp_pwm_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [1:0]        rsvdBits,
  input logic [MODE_W-1:0] modeQ,
  input logic [DATA_W-1:0] dataQ,
  input logic              pinOut,
  input logic              pinOe,
  input logic              intFlag,
  input logic              evtPulse
);
  logic flagClr, ctrlWr, dataWr, offMode;
  assign flagClr = busWrEn && (busAddr == ADDR_FLAG);
  assign ctrlWr  = busWrEn && (busAddr == ADDR_CTRL);
  assign dataWr  = busWrEn && (busAddr == ADDR_DLO || busAddr == ADDR_DHI);
  assign offMode = isOff(modeQ);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_CTRL) |-> (rsvdBits == 2'b00));

  // R3
  off_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offMode && !ctrlWr) |=> !pinOut);

  // R3
  off_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    offMode |-> !pinOe);

  // R4
  cap_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dataQ != $past(dataQ)) && !$past(dataWr)) |-> $past(isCapture(modeQ)));

  // R9
  evt_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);

  // R9
  evt_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |-> (intFlag && $past(modeQ) == M_CMP_EVT));

  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !flagClr) |=> intFlag);
endmodule

bind cap_cmp_pwm cap_cmp_pwm_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .rsvdBits(busRdData[7:6]), .modeQ(modeQ), .dataQ(dataQ),
  .pinOut(pinOut), .pinOe(pinOe), .intFlag(intFlag), .evtPulse(evtPulse)
);

// File: tb/cap_cmp_pwm_bench.sv
module cap_cmp_pwm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXC = 23;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [7:0]  busWrData = 8'd0;
  logic [7:0]  busRdData;
  logic [15:0] timerVal;
  logic [1:0]  pwmFine = 2'd0;
  logic        periodStart = 1'b0;
  logic        capIn = 1'b0;
  logic        pinOut, pinOe, intFlag, evtPulse;

  logic [15:0] tick = 16'd0;
  logic [15:0] manTimer = 16'd0;
  logic        useFree = 1'b0;
  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  assign timerVal = useFree ? tick : manTimer;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tick <= tick + 16'd1;

  cap_cmp_pwm u_cap_cmp_pwm (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .timerVal(timerVal),
    .pwmFine(pwmFine), .periodStart(periodStart), .capIn(capIn),
    .pinOut(pinOut), .pinOe(pinOe), .intFlag(intFlag), .evtPulse(evtPulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    nxt();
    busWrEn = 1'b0; busAddr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo);
    rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setT(input logic [15:0] v);
    manTimer = v;
    nxt();
  endtask

  // drive one capIn transition; load expected on the third edge after it
  task automatic capEdge(input logic val, input bit expLoad, input string req);
    logic [15:0] expV, prevV, gotV;
    rd16(prevV);
    capIn = val;
    nxt();
    nxt();
    expV = expLoad ? tick : prevV;
    nxt();
    rd16(gotV);
    chk(req, "captured data", int'(gotV), int'(expV));
    nxt();
  endtask

  task automatic pwmPeriod(input bit startEn, input bit doCheck, input int duty, input string req);
    for (int c = 0; c <= MAXC; c++) begin
      manTimer = 16'(c >> 2);
      pwmFine = 2'(c & 3);
      periodStart = startEn && (c == 0);
      nxt();
      if (doCheck) chk(req, $sformatf("pwm out count %0d duty %0d", c, duty), int'(pinOut), int'(c < duty));
    end
    periodStart = 1'b0;
  endtask

  task automatic setPwm(input int duty, input bit alt);
    wr(2'd0, 8'(duty >> 2));
    wr(2'd2, {2'b00, 2'(duty & 3), alt ? 4'b1111 : 4'b1100});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic        p0;
    int duties[11] = '{0, 1, 2, 5, 11, 12, 22, 23, 24, 40, 1023};

    // R1 reset state
    nxt(); nxt();
    rstN = 1'b1;
    nxt();
    rd16(w);   chk("R1", "data after reset", int'(w), 0);
    rd(2'd2, b); chk("R1", "ctrl after reset", int'(b), 0);
    rd(2'd3, b); chk("R1", "flag reg after reset", int'(b), 0);
    chk("R1", "pinOut", int'(pinOut), 0);
    chk("R1", "pinOe", int'(pinOe), 0);
    chk("R1", "evtPulse", int'(evtPulse), 0);

    // R2 register access
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    rd16(w); chk("R2", "data readback", int'(w), 16'h1234);
    wr(2'd2, 8'hFA);
    rd(2'd2, b); chk("R2", "ctrl readback reserved bits zero", int'(b), 8'h3A);
    wr(2'd2, 8'h00);

    // R4 single-edge capture
    useFree = 1'b1;
    wr(2'd2, 8'h05);
    capEdge(1'b1, 1'b1, "R4");
    chk("R4", "flag after capture", int'(intFlag), 1);
    capEdge(1'b0, 1'b0, "R4");
    // R12 clear by write
    wr(2'd3, 8'h00);
    chk("R12", "flag cleared by write", int'(intFlag), 0);
    wr(2'd2, 8'h04);
    capEdge(1'b1, 1'b0, "R4");
    capEdge(1'b0, 1'b1, "R4");

    // R5 prescaled capture
    wr(2'd2, 8'h06);
    for (int k = 1; k <= 8; k++) begin
      capEdge(1'b1, (k % 4) == 0, "R5");
      capEdge(1'b0, 1'b0, "R5");
    end
    for (int k = 1; k <= 2; k++) begin
      capEdge(1'b1, 1'b0, "R5");
      capEdge(1'b0, 1'b0, "R5");
    end
    wr(2'd2, 8'h06);
    for (int k = 1; k <= 4; k++) begin
      capEdge(1'b1, k == 4, "R5");
      capEdge(1'b0, 1'b0, "R5");
    end
    wr(2'd2, 8'h07);
    for (int k = 1; k <= 16; k++) begin
      capEdge(1'b1, k == 16, "R5");
      capEdge(1'b0, 1'b0, "R5");
    end

    // R6 toggle compare
    useFree = 1'b0;
    manTimer = 16'h0000;
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h02);
    p0 = pinOut;
    chk("R6", "pinOe in toggle mode", int'(pinOe), 1);
    setT(16'h1233); chk("R6", "no toggle before match", int'(pinOut), int'(p0));
    chk("R6", "no flag before match", int'(intFlag), 0);
    setT(16'h1234); chk("R6", "toggle on match", int'(pinOut), int'(!p0));
    chk("R6", "flag on match", int'(intFlag), 1);
    setT(16'h1234); chk("R6", "held match no retoggle", int'(pinOut), int'(!p0));
    setT(16'h1235);
    setT(16'h1234); chk("R6", "second match toggles back", int'(pinOut), int'(p0));

    // R7 force modes
    setT(16'h0000);
    wr(2'd2, 8'h09); chk("R7", "1001 entry high", int'(pinOut), 1);
    chk("R7", "pinOe in 1001", int'(pinOe), 1);
    wr(2'd3, 8'h00);
    setT(16'h1234); chk("R7", "1001 match low", int'(pinOut), 0);
    chk("R7", "1001 flag", int'(intFlag), 1);
    setT(16'h0000);
    wr(2'd2, 8'h09); chk("R7", "1001 re-entry high", int'(pinOut), 1);
    wr(2'd2, 8'h08); chk("R7", "1000 entry low", int'(pinOut), 0);
    setT(16'h1234); chk("R7", "1000 match high", int'(pinOut), 1);

    // R8 flag-only compare
    setT(16'h0000);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h0A);
    p0 = pinOut;
    chk("R8", "pinOe in 1010", int'(pinOe), 0);
    setT(16'h1234); chk("R8", "flag on match", int'(intFlag), 1);
    chk("R8", "pin latch unchanged", int'(pinOut), int'(p0));
    chk("R8", "no event", int'(evtPulse), 0);

    // R9 event trigger
    setT(16'h0000);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h0B);
    chk("R9", "pinOe in 1011", int'(pinOe), 0);
    setT(16'h1234); chk("R9", "event pulse high", int'(evtPulse), 1);
    chk("R9", "flag with event", int'(intFlag), 1);
    nxt(); chk("R9", "event pulse one cycle", int'(evtPulse), 0);

    // R12 set wins over clear
    setT(16'h0000);
    wr(2'd3, 8'h00);
    chk("R12", "flag clear", int'(intFlag), 0);
    manTimer = 16'h1234;
    wr(2'd3, 8'h00);
    chk("R12", "set beats clear", int'(intFlag), 1);
    nxt(); chk("R12", "flag sticky", int'(intFlag), 1);

    // R3 disabled and reserved codes
    foreach (duties[i]) begin
      logic [3:0] code;
      if (i > 2) break;
      code = (i == 0) ? 4'b0000 : (i == 1) ? 4'b0001 : 4'b0011;
      setT(16'h0000);
      wr(2'd2, 8'h09);
      wr(2'd3, 8'h00);
      wr(2'd2, {4'h0, code});
      nxt();
      chk("R3", $sformatf("pin low code %0d", code), int'(pinOut), 0);
      chk("R3", "pinOe off", int'(pinOe), 0);
      setT(16'h1234);
      chk("R3", "no flag on match", int'(intFlag), 0);
      chk("R3", "no event", int'(evtPulse), 0);
      manTimer = 16'h0777;
      capEdge(1'b1, 1'b0, "R3");
      capEdge(1'b0, 1'b0, "R3");
      chk("R3", "no flag on edges", int'(intFlag), 0);
    end

    // R10 / R11 PWM sweep
    foreach (duties[i]) begin
      setPwm(duties[i], i[0]);
      if (i == 0) chk("R10", "pinOe in pwm", int'(pinOe), 1);
      pwmPeriod(1'b1, 1'b0, duties[i], "R10");
      pwmPeriod(1'b1, 1'b1, duties[i], duties[i] > MAXC || duties[i] == 0 ? "R11" : "R10");
    end
    // R10 double buffering
    setPwm(5, 1'b0);
    pwmPeriod(1'b1, 1'b1, 5, "R10");
    setPwm(20, 1'b0);
    pwmPeriod(1'b0, 1'b1, 5, "R10");
    pwmPeriod(1'b1, 1'b1, 20, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule